// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is the synchronous front end of a pipelined burst static memory. It runs on a single clock. It takes a start address from either of two address strobes: a processor strobe and a controller strobe. Chip selection comes from three enables, and the first enable can block the processor strobe. Once an access has started, an advance input steps it through a burst of four beats inside the aligned group of four words. Writes are made per byte lane, or to all lanes at once. Reads come back on a registered output one cycle after the access is captured. The storage is a small parameterised array.

A snooze input puts the block into a low-power state. The block keeps the array contents while the clock runs. Accesses are refused while the block is asleep and for two cycles after it wakes. A static mode input chooses the beat order. Output enable only qualifies the data-valid flag. There is no pad or tri-state behaviour.

Top module: `pbsram_front`

## Requirements
- R1: The address is 15 bits and the data is 32 bits. An access captured at clock edge k returns the stored word at address bits [MEM_AW-1:0] on `rdata` after edge k+1, with `rd_any` set at the same time. With the defaults, MEM_AW is 6 (64 words).
- R2: `en_sec` and `en_ter` are sampled only in a cycle with an accepted strobe. In every other cycle they have no effect, and an active burst keeps advancing.
- R3: When `cpu_strobe` is high and `en_pri` is low, with no `ctl_strobe`, the strobe is blocked. It starts no access and leaves the selection unchanged.
- R4: An accepted strobe (processor strobe with `en_pri` high, or controller strobe) while any enable is low deselects the block. `rdata` is 0 after the second edge, and `adv` has no effect until the block is selected again.
- R5: A selected start is beat 0. Each later cycle with `adv` high and no accepted strobe performs the next beat, up to beat 3. `adv` after beat 3 performs nothing. A strobe takes precedence over `adv`.
- R6: Beat n uses the start address with its low two bits replaced. With `burst_mode`=0 (linear) they are (start + n) mod 4. With `burst_mode`=1 they are start XOR n. Bits above the low two never change.
- R7: A beat with `wr_all` high writes all four lanes. Otherwise, with `wr_byte_en` high, it writes each lane i whose `wr_lane[i]` is set; lane i is data bits [8i+7:8i]. A writing beat returns no read data.
- R8: `rvalid` equals the internal read-data flag ANDed with `out_en`. `out_en` does not change `rdata`.
- R9: `snooze` high blocks accesses in that cycle. Held high across two edges, it sets `asleep` after the second edge, and `asleep` stays set while `snooze` stays high. Array contents survive the snooze.
- R10: From the cycle in which `snooze` is first seen low while asleep, strobes and `adv` are ignored for that cycle and the next two.
- R11: After reset the block is unselected, awake, and has no burst in progress. `rdata`=0, `rvalid`=0 and `asleep`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | Processor address strobe, masked by `en_pri` |
| ctl_strobe | input | 1 | Controller address strobe |
| adv | input | 1 | Advance to next burst beat |
| en_pri | input | 1 | Primary chip enable |
| en_sec | input | 1 | Second chip enable |
| en_ter | input | 1 | Third chip enable |
| wr_all | input | 1 | Write all lanes |
| wr_byte_en | input | 1 | Allow per-lane writes |
| wr_lane | input | 4 | Per-lane write strobes |
| out_en | input | 1 | Output enable, gates `rvalid` |
| snooze | input | 1 | Low-power request |
| burst_mode | input | 1 | Static beat order: 0 linear, 1 interleaved |
| addr | input | 15 | Start address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, 0 when idle |
| rvalid | output | 1 | Read data valid, qualified by `out_en` |
| asleep | output | 1 | Low-power state reached |

## Verification
The in-line assertions check several rules on every cycle:
- selection holds when no strobe is accepted;
- a blocked processor strobe leaves the selection unchanged;
- a deselecting strobe idles the data two edges later;
- beat counting and group alignment of the beat address;
- a write returns no read data;
- the snooze entry steps, and no access while not awake.

The bench scenarios are needed for the rest:
- the stored values read back after byte-masked writes;
- the exact beat order in both modes;
- retention across a snooze;
- the three-cycle ignore window after release.

A cycle model built from the requirements predicts every output in a long random run.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned BEATS  = 4;

  typedef enum logic [2:0] {
    NAP_AWAKE = 3'd0,
    NAP_ENTER = 3'd1,
    NAP_SLEEP = 3'd2,
    NAP_REC1  = 3'd3,
    NAP_REC2  = 3'd4
  } nap_state_e;
endpackage

// File: rtl/pbsram_select.sv
module pbsram_select (
  input  logic clk,
  input  logic rst_ni,
  input  logic go,
  input  logic all_en,
  output logic sel_q
);
  logic sel_d;

  always_comb begin
    sel_d = sel_q;
    if (go) sel_d = all_en;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !go |=> $stable(sel_q));
endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start,
  input  logic              step,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [1:0]        beat_q,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_d, nxt, lo;

  assign nxt = beat_q + 2'd1;

  always_comb begin
    if (mode) lo = base_q[1:0] ^ nxt;
    else      lo = base_q[1:0] + nxt;
    if (start) acc_addr = addr_in;
    else       acc_addr = {base_q[ADDR_W-1:2], lo};
  end

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    if (start) begin
      base_d = addr_in;
      beat_d = 2'd0;
    end else if (step) begin
      beat_d = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= 2'd3;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assert_start_beat_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> beat_q == 2'd0);
  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (step && !start) |=> beat_q == $past(beat_q) + 2'd1);
  assert_group_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (step && !start) |-> acc_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]);
endmodule

// File: rtl/pbsram_snooze.sv
module pbsram_snooze
  import pbsram_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic snooze,
  output logic awake_ok,
  output logic asleep
);
  nap_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      NAP_AWAKE: if (snooze) st_d = NAP_ENTER;
      NAP_ENTER: st_d = snooze ? NAP_SLEEP : NAP_REC1;
      NAP_SLEEP: if (!snooze) st_d = NAP_REC1;
      NAP_REC1:  st_d = NAP_REC2;
      NAP_REC2:  st_d = NAP_AWAKE;
      default:   st_d = NAP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= NAP_AWAKE;
    else         st_q <= st_d;
  end

  assign awake_ok = (st_q == NAP_AWAKE) && !snooze;
  assign asleep   = (st_q == NAP_SLEEP);

  assert_enter_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == NAP_AWAKE && snooze) |=> st_q == NAP_ENTER);
  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == NAP_ENTER && snooze) |=> asleep);
  assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (asleep && !snooze) |=> (!awake_ok ##1 !awake_ok));
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
  import pbsram_pkg::*;
#(
  parameter int unsigned MEM_AW = 6,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  mask,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [DW-1:0]     wdata,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [DW-1:0]     rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && mask[l]) bank[wr_idx] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = bank[rd_idx];
  end
endmodule

// File: rtl/pbsram_front.sv
module pbsram_front
  import pbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned LANES  = 4,
  parameter int unsigned MEM_AW = 6,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe,
  input  logic              ctl_strobe,
  input  logic              adv,
  input  logic              en_pri,
  input  logic              en_sec,
  input  logic              en_ter,
  input  logic              wr_all,
  input  logic              wr_byte_en,
  input  logic [LANES-1:0]  wr_lane,
  input  logic              out_en,
  input  logic              snooze,
  input  logic              burst_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              asleep
);
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  logic awake_ok, sel_q, go, all_en, start, step, acc_fire, wr_any;
  logic [1:0]        beat_q;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  mask;
  logic [DW-1:0]     rd_data;
  logic              unused_addr_hi;

  assign all_en   = en_pri && en_sec && en_ter;
  assign go       = awake_ok && ((cpu_strobe && en_pri) || ctl_strobe);
  assign start    = go && all_en;
  assign step     = awake_ok && !go && sel_q && adv && (beat_q != 2'd3);
  assign acc_fire = start || step;
  assign mask     = wr_all ? '1 : (wr_byte_en ? wr_lane : '0);
  assign wr_any   = |mask;
  assign unused_addr_hi = ^acc_addr[ADDR_W-1:MEM_AW];

  pbsram_snooze u_nap (
    .clk(clk), .rst_ni(rst_q), .snooze(snooze),
    .awake_ok(awake_ok), .asleep(asleep));

  pbsram_select u_sel (
    .clk(clk), .rst_ni(rst_q), .go(go), .all_en(all_en), .sel_q(sel_q));

  pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_ni(rst_q), .start(start), .step(step),
    .mode(burst_mode), .addr_in(addr), .beat_q(beat_q), .acc_addr(acc_addr));

  // pipeline: stage 1 holds the captured read address, stage 2 the data
  logic              acc_v_q, acc_v_d, rd_q, rd_d;
  logic [MEM_AW-1:0] acc_idx_q, acc_idx_d;
  logic [DW-1:0]     rdata_q, rdata_d;

  pbsram_array #(.MEM_AW(MEM_AW), .LANES(LANES)) u_mem (
    .clk(clk), .we(acc_fire), .mask(mask), .wr_idx(acc_addr[MEM_AW-1:0]),
    .wdata(wdata), .rd_idx(acc_idx_q), .rd_data(rd_data));

  always_comb begin
    acc_v_d   = acc_fire && !wr_any;
    acc_idx_d = acc_fire ? acc_addr[MEM_AW-1:0] : acc_idx_q;
    rd_d      = acc_v_q;
    rdata_d   = acc_v_q ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      acc_v_q   <= 1'b0;
      acc_idx_q <= '0;
      rd_q      <= 1'b0;
      rdata_q   <= '0;
    end else begin
      acc_v_q   <= acc_v_d;
      acc_idx_q <= acc_idx_d;
      rd_q      <= rd_d;
      rdata_q   <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rd_q && out_en;

  assert_cpu_blocked_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_strobe && !en_pri && !ctl_strobe) |=> $stable(sel_q));
  assert_unsel_idle_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (go && !all_en) |=> ##1 (rdata == '0 && !rd_q));
  assert_write_noread_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_fire && wr_any) |=> ##1 !rd_q);
  assert_blocked_nap_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !awake_ok |-> !acc_fire);
  assert_read_lat_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_fire && !wr_any) |=> ##1 rd_q);
endmodule

// File: tb/pbsram_front_tb.sv
module pbsram_front_tb;
  localparam int AW = 15;
  localparam int MAW = 6;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_strobe, ctl_strobe, adv, en_pri, en_sec, en_ter;
  logic wr_all, wr_byte_en, out_en, snooze, burst_mode;
  logic [3:0]    wr_lane;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rvalid, asleep;

  always #4 clk = ~clk;

  pbsram_front u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe),
    .adv(adv), .en_pri(en_pri), .en_sec(en_sec), .en_ter(en_ter),
    .wr_all(wr_all), .wr_byte_en(wr_byte_en), .wr_lane(wr_lane),
    .out_en(out_en), .snooze(snooze), .burst_mode(burst_mode),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .asleep(asleep));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0]   mem [DEPTH];
  bit            m_sel, m_accv, m_rdv;
  logic [1:0]    m_beat;
  logic [AW-1:0] m_base;
  logic [MAW-1:0] m_acc;
  logic [31:0]   m_rdata;
  int            m_st;

  function automatic logic [1:0] beat_lo(input logic [1:0] s, input logic [1:0] n,
                                         input logic md);
    return md ? (s ^ n) : (s + n);
  endfunction

  task automatic model_reset();
    m_sel = 0; m_accv = 0; m_rdv = 0; m_beat = 2'd3; m_base = '0;
    m_acc = '0; m_rdata = '0; m_st = 0;
  endtask

  task automatic model_step();
    bit ok, go, alle, start, step, fire, isw;
    logic [AW-1:0] a;
    logic [3:0] mk;
    logic [1:0] nb;
    ok    = (m_st == 0) && !snooze;
    go    = ok && ((cpu_strobe && en_pri) || ctl_strobe);
    alle  = en_pri && en_sec && en_ter;
    start = go && alle;
    step  = ok && !go && m_sel && adv && (m_beat != 2'd3);
    fire  = start || step;
    nb    = m_beat + 2'd1;
    a     = start ? addr : {m_base[AW-1:2], beat_lo(m_base[1:0], nb, burst_mode)};
    mk    = wr_all ? 4'hF : (wr_byte_en ? wr_lane : 4'h0);
    isw   = |mk;
    m_rdata = m_accv ? mem[m_acc] : '0;
    m_rdv   = m_accv;
    if (fire && isw)
      for (int l = 0; l < 4; l++)
        if (mk[l]) mem[a[MAW-1:0]][l*8 +: 8] = wdata[l*8 +: 8];
    m_accv = fire && !isw;
    if (fire) m_acc = a[MAW-1:0];
    if (go) m_sel = alle;
    if (start) begin m_base = addr; m_beat = 2'd0; end
    else if (step) m_beat = nb;
    case (m_st)
      0: if (snooze) m_st = 1;
      1: m_st = snooze ? 2 : 3;
      2: if (!snooze) m_st = 3;
      3: m_st = 4;
      default: m_st = 0;
    endcase
  endtask

  task automatic idle();
    cpu_strobe = 0; ctl_strobe = 0; adv = 0; en_pri = 1; en_sec = 1; en_ter = 1;
    wr_all = 0; wr_byte_en = 0; wr_lane = 4'h0; out_en = 1; snooze = 0;
    addr = '0; wdata = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] got_d, input logic [31:0] exp_d,
                       input string what);
    checks++;
    if (got_d !== exp_d) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got_d, exp_d);
    end
  endtask

  // one clock: inputs already driven; model on the edge; compare at the falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    check(tag, rdata, m_rdata, "rdata");
    check(tag, {31'd0, rvalid}, {31'd0, m_rdv && out_en}, "rvalid");
    check(tag, {31'd0, asleep}, {31'd0, m_st == 2}, "asleep");
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick("R11"); tick("R11"); tick("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    burst_mode = 0;
    do_reset();
    // R11: adv alone does nothing after reset
    adv = 1; tick("R11"); tick("R11"); adv = 0; tick("R11");
    check("R11", rdata, 32'd0, "rdata after reset");

    // R7: fill every word with full-lane write bursts
    for (int g = 0; g < DEPTH / 4; g++) begin
      idle(); ctl_strobe = 1; wr_all = 1; addr = AW'(g * 4); wdata = $urandom; tick("R7");
      for (int b = 0; b < 3; b++) begin
        idle(); adv = 1; wr_all = 1; wdata = $urandom; tick("R7");
      end
    end
    idle(); tick("R7");

    // R1/R5/R6: linear burst from low bits 2, then an extra adv that is ignored
    idle(); cpu_strobe = 1; addr = 15'h0106; tick("R1");
    for (int b = 0; b < 4; b++) begin idle(); adv = 1; tick("R5"); end
    idle(); tick("R6"); tick("R6");
    check("R6", {31'd0, rvalid}, 32'd0, "no beat after fourth");

    // R7: lane-masked write then read back
    idle(); ctl_strobe = 1; wr_byte_en = 1; wr_lane = 4'b0101; addr = 15'h0009;
    wdata = 32'hA1B2C3D4; tick("R7");
    idle(); ctl_strobe = 1; addr = 15'h0009; tick("R7");
    idle(); tick("R7"); tick("R7");
    idle(); ctl_strobe = 1; addr = 15'h0009; tick("R7"); idle(); tick("R7");
    check("R7", rdata[23:16], 8'hB2, "lane 2 written");

    // R2: secondary/tertiary enables ignored between strobes
    idle(); ctl_strobe = 1; addr = 15'h0011; tick("R2");
    idle(); adv = 1; en_sec = 0; tick("R2");
    idle(); adv = 1; en_ter = 0; tick("R2");
    idle(); tick("R2"); tick("R2");

    // R3: blocked processor strobe while primary enable low
    idle(); cpu_strobe = 1; en_pri = 0; addr = 15'h0020; tick("R3");
    idle(); tick("R3"); tick("R3");
    check("R3", {31'd0, rvalid}, 32'd0, "blocked strobe read");

    // R4: deselect via controller strobe with third enable low
    idle(); ctl_strobe = 1; addr = 15'h0030; tick("R4");
    idle(); ctl_strobe = 1; en_ter = 0; addr = 15'h0034; tick("R4");
    idle(); adv = 1; tick("R4"); tick("R4"); tick("R4");
    check("R4", rdata, 32'd0, "idle data after deselect");

    // R8: output enable low hides valid but not data
    idle(); ctl_strobe = 1; addr = 15'h0003; tick("R8");
    idle(); out_en = 0; tick("R8");
    check("R8", {31'd0, rvalid}, 32'd0, "valid gated");
    check("R8", rdata, mem[3], "data kept");
    idle(); tick("R8");

    // R9/R10: snooze with attempted accesses, then release with strobes
    idle(); snooze = 1; ctl_strobe = 1; addr = 15'h0005; tick("R9");
    idle(); snooze = 1; tick("R9");
    check("R9", {31'd0, asleep}, 32'd1, "asleep after two edges");
    for (int k = 0; k < 4; k++) begin
      idle(); snooze = 1; cpu_strobe = 1; addr = 15'h0007; wr_all = 1; wdata = 32'hDEAD0000; tick("R9");
    end
    for (int k = 0; k < 3; k++) begin
      idle(); ctl_strobe = 1; addr = 15'h0008; tick("R10");
    end
    idle(); tick("R10"); tick("R10");
    check("R10", {31'd0, rvalid}, 32'd0, "strobes during recovery ignored");
    idle(); ctl_strobe = 1; addr = 15'h0007; tick("R9"); idle(); tick("R9"); tick("R9");

    // R6: interleaved order
    do_reset();
    burst_mode = 1;
    idle(); ctl_strobe = 1; addr = 15'h0017; tick("R6");
    for (int b = 0; b < 4; b++) begin idle(); adv = 1; tick("R6"); end
    idle(); tick("R6"); tick("R6");

    // random phase, both modes
    for (int ph = 0; ph < 2; ph++) begin
      burst_mode = ph[0];
      do_reset();
      for (int c = 0; c < 4000; c++) begin
        int r;
        idle();
        r = $urandom_range(99);
        cpu_strobe = (r < 12);
        ctl_strobe = (r >= 12 && r < 20);
        adv        = ($urandom_range(99) < 60);
        en_pri     = ($urandom_range(99) < 85);
        en_sec     = ($urandom_range(99) < 90);
        en_ter     = ($urandom_range(99) < 90);
        wr_all     = ($urandom_range(99) < 10);
        wr_byte_en = ($urandom_range(99) < 20);
        wr_lane    = 4'($urandom);
        out_en     = ($urandom_range(99) < 80);
        snooze     = ((c % 500) >= 480) || ($urandom_range(99) < 2);
        addr       = AW'($urandom);
        wdata      = $urandom;
        tick("R1");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule